// File: doc/BRIEF.md
# Set/Clear GPIO Controller

A general-purpose I/O block on a small memory-mapped register bus with a 32-bit data word and one register per word address. Software reads the level of every pin through a data word and changes the output latch bit by bit through a set word and a clear word, so no read-modify-write is needed. A direction word chooses, per line, whether the line is driven or only sampled. The block presents a per-line output value and output enable to the pad ring and takes a per-line input back through a two-flop synchroniser.

The block is shaped at build time. It can have fewer connected lines than the word width. It can omit the clear word, in which case the set word loads the latch outright. It can read its direction bits with either polarity. It can be built input-only, and it can put register bytes on the bus in either byte order.

Word map (address bits [1:0], upper address bits zero): 0 = pin levels (read-only), 1 = set, 2 = clear, 3 = direction.

Top module: `gpio_mmio_top`

## Requirements
- R1: A read of word 0 returns, in bit n, the level of input line n after the two-flop synchroniser. A level held for at least two rising edges before the edge that takes the read is returned. Read data appears on `busRdata` after the edge that samples `busRe` and holds until the next read.
- R2: With a clear word present, writing word 1 sets each latch bit whose write bit is 1. Bits written 0 keep their value. `pinOut` follows the latch after the writing edge and changes on no other edge.
- R3: With a clear word present, writing word 2 clears each latch bit whose write bit is 1. Bits written 0 keep their value.
- R4: Without a clear word (`HAS_CLEAR`=0), writing word 1 loads the latch with the write data, so 0 bits drive low. Writes to word 2 change nothing.
- R5: With `DIR_IS_OUT`=1, a 1 in direction bit n asserts `pinOe[n]` and a 0 deasserts it.
- R6: With `DIR_IS_OUT`=0, a 1 in direction bit n deasserts `pinOe[n]` (input) and a 0 asserts it.
- R7: Bits at or above `NUM_LINES` read as 0 in every word, ignore writes, and keep `pinOe` and `pinOut` at 0.
- R8: With `INPUT_ONLY`=1, `pinOe` is 0 at all times, whatever is written.
- R9: With `BIG_ENDIAN`=1, register byte k (bits 8k+7..8k) travels on bus byte 3-k for both writes and reads. With `BIG_ENDIAN`=0, the bytes are not reordered.
- R10: After reset, every line is an input (`pinOe`=0), the latch is 0, and word 3 reads as the all-input encoding: 0 for `DIR_IS_OUT`=1, or 1 in every connected bit for `DIR_IS_OUT`=0.
- R11: Reads of words 1 and 2 return the output latch, and reads of word 3 return the direction bits as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Write strobe for one cycle |
| busRe | input | 1 | Read strobe for one cycle |
| busAddr | input | ADDR_W | Word address |
| busWdata | input | 32 | Write data in bus byte order |
| busRdata | output | 32 | Registered read data in bus byte order |
| pinIn | input | 32 | Asynchronous line levels |
| pinOut | output | 32 | Output latch value per line |
| pinOe | output | 32 | Output enable per line |

## Verification
A write takes effect on `pinOut` and `pinOe` at the edge that samples it, so the bench checks the pins at the falling edge that follows. Read data is registered, so it is due at the falling edge after the edge that samples `busRe`. The scoreboard monitor pops one expected word at that moment for each read the bench issued. A pin change needs two edges to cross the synchroniser before a read can see it, so the bench lets three cycles pass after changing `pinIn` before it reads word 0.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    REG_LEVEL = 2'd0,
    REG_SET   = 2'd1,
    REG_CLR   = 2'd2,
    REG_DIR   = 2'd3
  } regSel_t;

  typedef struct packed {
    logic    wrSet;
    logic    wrClr;
    logic    wrDir;
    logic    rdEn;
    logic    rdHit;
    regSel_t rdSel;
  } gpioStrobe_t;

  function automatic logic [DATA_W-1:0] byteSwap(input logic [DATA_W-1:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter bit HAS_CLEAR  = 1'b1,
  parameter bit INPUT_ONLY = 1'b0,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] rdWord,
  output logic [DATA_W-1:0] wrData,
  output gpioStrobe_t       stb
);

  localparam int HI_W = ADDR_W - 2;

  logic    addrHit;
  regSel_t regIdx;
  logic [DATA_W-1:0] rdBus;
  logic [DATA_W-1:0] rdQ;

  assign addrHit = (busAddr[ADDR_W-1:2] == HI_W'(0));
  assign regIdx  = regSel_t'(busAddr[1:0]);

  // Byte order on the bus side only; the datapath always sees register order.
  generate
    if (BIG_ENDIAN) begin : g_swap
      assign wrData = byteSwap(busWdata);
      assign rdBus  = byteSwap(rdWord);
    end else begin : g_pass
      assign wrData = busWdata;
      assign rdBus  = rdWord;
    end
  endgenerate

  always_comb begin
    stb       = '0;
    stb.rdEn  = busRe;
    stb.rdHit = addrHit;
    stb.rdSel = regIdx;
    if (busWe && addrHit && !INPUT_ONLY) begin
      unique case (regIdx)
        REG_SET: stb.wrSet = 1'b1;
        REG_CLR: stb.wrClr = HAS_CLEAR;
        REG_DIR: stb.wrDir = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ <= '0;
    end else if (stb.rdEn) begin
      rdQ <= rdBus;
    end
  end

  assign busRdata = rdQ;

endmodule

// File: rtl/gpio_dpath.sv
module gpio_dpath
  import gpio_pkg::*;
#(
  parameter int NUM_LINES  = 24,
  parameter bit HAS_CLEAR  = 1'b1,
  parameter bit DIR_IS_OUT = 1'b1,
  parameter bit INPUT_ONLY = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  gpioStrobe_t       stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] pinIn,
  output logic [DATA_W-1:0] pinOut,
  output logic [DATA_W-1:0] pinOe,
  output logic [DATA_W-1:0] rdWord
);

  localparam logic DIR_RESET = ~DIR_IS_OUT;

  logic [DATA_W-1:0] levelVec;
  logic [DATA_W-1:0] latchVec;
  logic [DATA_W-1:0] dirVec;

  for (genvar i = 0; i < DATA_W; i++) begin : g_line
    if (i < NUM_LINES) begin : g_live
      logic syncA, syncB, latchBit, dirBit;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          syncA    <= 1'b0;
          syncB    <= 1'b0;
          latchBit <= 1'b0;
          dirBit   <= DIR_RESET;
        end else begin
          syncA <= pinIn[i];
          syncB <= syncA;
          if (HAS_CLEAR) begin
            // Clear wins over set on the same bit.
            if (stb.wrClr && wrData[i])      latchBit <= 1'b0;
            else if (stb.wrSet && wrData[i]) latchBit <= 1'b1;
          end else if (stb.wrSet) begin
            latchBit <= wrData[i];
          end
          if (stb.wrDir) dirBit <= wrData[i];
        end
      end

      assign levelVec[i] = syncB;
      assign latchVec[i] = latchBit;
      assign dirVec[i]   = dirBit;
      assign pinOut[i]   = latchBit;
      assign pinOe[i]    = INPUT_ONLY ? 1'b0 : (DIR_IS_OUT ? dirBit : ~dirBit);
    end else begin : g_dead
      assign levelVec[i] = 1'b0;
      assign latchVec[i] = 1'b0;
      assign dirVec[i]   = 1'b0;
      assign pinOut[i]   = 1'b0;
      assign pinOe[i]    = 1'b0;
    end
  end

  // Unconnected lines leave some input bits unread.
  logic unusedBits;
  assign unusedBits = ^{pinIn, wrData};

  always_comb begin
    rdWord = '0;
    if (stb.rdHit) begin
      unique case (stb.rdSel)
        REG_LEVEL: rdWord = levelVec;
        REG_SET,
        REG_CLR:   rdWord = latchVec;
        REG_DIR:   rdWord = dirVec;
        default:   rdWord = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_mmio_top.sv
module gpio_mmio_top
  import gpio_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int NUM_LINES  = 24,
  parameter bit HAS_CLEAR  = 1'b1,
  parameter bit DIR_IS_OUT = 1'b1,
  parameter bit INPUT_ONLY = 1'b0,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [31:0]       pinIn,
  output logic [31:0]       pinOut,
  output logic [31:0]       pinOe
);

  gpioStrobe_t       stb;
  logic [DATA_W-1:0] wrData;
  logic [DATA_W-1:0] rdWord;

  gpio_ctrl #(
    .ADDR_W    (ADDR_W),
    .HAS_CLEAR (HAS_CLEAR),
    .INPUT_ONLY(INPUT_ONLY),
    .BIG_ENDIAN(BIG_ENDIAN)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busWe   (busWe),
    .busRe   (busRe),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .rdWord  (rdWord),
    .wrData  (wrData),
    .stb     (stb)
  );

  gpio_dpath #(
    .NUM_LINES (NUM_LINES),
    .HAS_CLEAR (HAS_CLEAR),
    .DIR_IS_OUT(DIR_IS_OUT),
    .INPUT_ONLY(INPUT_ONLY)
  ) u_dpath (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .wrData(wrData),
    .pinIn (pinIn),
    .pinOut(pinOut),
    .pinOe (pinOe),
    .rdWord(rdWord)
  );

endmodule

// File: rtl/gpio_mmio_chk.sv
module gpio_mmio_chk
  import gpio_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int NUM_LINES  = 24,
  parameter bit HAS_CLEAR  = 1'b1,
  parameter bit DIR_IS_OUT = 1'b1,
  parameter bit INPUT_ONLY = 1'b0,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       pinOut,
  input logic [31:0]       pinOe
);

  localparam logic [31:0] LIVE = (NUM_LINES >= 32) ? '1 : ((32'd1 << NUM_LINES) - 32'd1);
  localparam int HI_W = ADDR_W - 2;

  logic [31:0] regVal;
  logic hiZero, setHit, clrHit, dirHit;

  assign regVal = BIG_ENDIAN ? byteSwap(busWdata) : busWdata;
  assign hiZero = (busAddr[ADDR_W-1:2] == HI_W'(0));
  assign setHit = busWe && hiZero && (busAddr[1:0] == 2'd1);
  assign clrHit = busWe && hiZero && (busAddr[1:0] == 2'd2);
  assign dirHit = busWe && hiZero && (busAddr[1:0] == 2'd3);

  AST_DEAD_LINES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOe | pinOut) & ~LIVE) == 32'd0); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |=> $stable(pinOut)); // R2

  if (INPUT_ONLY) begin : g_ro
    AST_NEVER_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
      pinOe == 32'd0); // R8
  end else begin : g_rw
    AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rstN)
      dirHit |=> pinOe == ((DIR_IS_OUT ? $past(regVal) : ~$past(regVal)) & LIVE)); // R5 R6
    if (HAS_CLEAR) begin : g_clr
      AST_SET_HIGH: assert property (@(posedge clk) disable iff (!rstN)
        setHit |=> (pinOut & $past(regVal) & LIVE) == ($past(regVal) & LIVE)); // R2
      AST_CLR_LOW: assert property (@(posedge clk) disable iff (!rstN)
        clrHit |=> (pinOut & $past(regVal) & LIVE) == 32'd0); // R3
    end else begin : g_noclr
      AST_SET_LOAD: assert property (@(posedge clk) disable iff (!rstN)
        setHit |=> pinOut == ($past(regVal) & LIVE)); // R4
      AST_CLR_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
        clrHit |=> $stable(pinOut)); // R4
    end
  end

endmodule

bind gpio_mmio_top gpio_mmio_chk #(
  .ADDR_W    (ADDR_W),
  .NUM_LINES (NUM_LINES),
  .HAS_CLEAR (HAS_CLEAR),
  .DIR_IS_OUT(DIR_IS_OUT),
  .INPUT_ONLY(INPUT_ONLY),
  .BIG_ENDIAN(BIG_ENDIAN)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busWe   (busWe),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .pinOut  (pinOut),
  .pinOe   (pinOe)
);

// File: tb/gpio_mmio_top_bench.sv
`timescale 1ns/1ps
module gpio_mmio_top_bench;

  typedef struct {
    int          inst;
    logic [31:0] exp;
    string       tag;
  } rdItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busWe = '0;
  logic [2:0]  busRe = '0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] pinIn = '0;
  logic [31:0] rdData [3];
  logic [31:0] outV [3];
  logic [31:0] oeV [3];

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;
  rdItem_t rdQ[$];
  logic rdFired = 1'b0;

  always #10 clk = ~clk;

  // Default build: 24 lines, clear word, 1 = output, little-endian
  gpio_mmio_top u_gpio_mmio_top (
    .clk(clk), .rstN(rstN), .busWe(busWe[0]), .busRe(busRe[0]),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(rdData[0]),
    .pinIn(pinIn), .pinOut(outV[0]), .pinOe(oeV[0]));

  // Alternate build: 12 lines, no clear word, 1 = input, big-endian
  gpio_mmio_top #(.NUM_LINES(12), .HAS_CLEAR(1'b0), .DIR_IS_OUT(1'b0), .BIG_ENDIAN(1'b1))
  u_gpio_mmio_top_alt (
    .clk(clk), .rstN(rstN), .busWe(busWe[1]), .busRe(busRe[1]),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(rdData[1]),
    .pinIn(pinIn), .pinOut(outV[1]), .pinOe(oeV[1]));

  // Input-only build, all 32 lines
  gpio_mmio_top #(.NUM_LINES(32), .INPUT_ONLY(1'b1))
  u_gpio_mmio_top_ro (
    .clk(clk), .rstN(rstN), .busWe(busWe[2]), .busRe(busRe[2]),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(rdData[2]),
    .pinIn(pinIn), .pinOut(outV[2]), .pinOe(oeV[2]));

  function automatic logic [31:0] swp(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input int inst, input logic [3:0] addr, input logic [31:0] data);
    @(negedge clk);
    busAddr     = addr;
    busWdata    = data;
    busWe[inst] = 1'b1;
    @(negedge clk);
    busWe = '0;
  endtask

  // Driver: issue a read and push its expected word
  task automatic doRead(input int inst, input logic [3:0] addr, input logic [31:0] exp,
                        input string tag);
    rdItem_t it;
    @(negedge clk);
    busAddr     = addr;
    busRe[inst] = 1'b1;
    it.inst = inst;
    it.exp  = exp;
    it.tag  = tag;
    rdQ.push_back(it);
    @(negedge clk);
    busRe = '0;
  endtask

  always @(posedge clk) rdFired <= |busRe;

  // Monitor: read data is due at the falling edge after the sampling edge
  always @(negedge clk) begin
    if (rdFired) begin
      if (rdQ.size() == 0) begin
        check("read without expectation", 32'd1, 32'd0);
      end else begin
        rdItem_t it;
        it = rdQ.pop_front();
        check(it.tag, rdData[it.inst], it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10 oe default", oeV[0], 32'h0);
    check("R10 out default", outV[0], 32'h0);
    check("R10 oe alt", oeV[1], 32'h0);
    doRead(0, 4'd3, 32'h0, "R10 dir read default");
    doRead(1, 4'd3, swp(32'h0000_0FFF), "R10 R9 dir read alt");

    // R2 R7 set on default build
    doWrite(0, 4'd1, 32'hFF00_F00F);
    check("R2 R7 set", outV[0], 32'h0000_F00F);
    doWrite(0, 4'd1, 32'h0000_0F00);
    check("R2 zeros keep", outV[0], 32'h0000_FF0F);
    doWrite(0, 4'd2, 32'hFF00_1001);
    check("R3 clear", outV[0], 32'h0000_EF0E);
    doRead(0, 4'd1, 32'h0000_EF0E, "R11 set word read");
    doRead(0, 4'd2, 32'h0000_EF0E, "R11 clear word read");

    // R5 R7 direction
    doWrite(0, 4'd3, 32'hFFFF_00FF);
    check("R5 R7 oe", oeV[0], 32'h00FF_00FF);
    doRead(0, 4'd3, 32'h00FF_00FF, "R11 R7 dir read");
    doWrite(0, 4'd3, 32'h0000_0F00);
    check("R5 zero is input", oeV[0], 32'h0000_0F00);

    // R1 R7 level read
    @(negedge clk);
    pinIn = 32'hA5C3_5A69;
    repeat (3) @(negedge clk);
    doRead(0, 4'd0, 32'h00C3_5A69, "R1 R7 level read");
    doRead(1, 4'd0, swp(32'h0000_0A69), "R1 R9 level read alt");
    doRead(2, 4'd0, 32'hA5C3_5A69, "R1 level read ro");
    @(negedge clk);
    pinIn = 32'h0000_0001;
    repeat (3) @(negedge clk);
    doRead(0, 4'd0, 32'h0000_0001, "R1 level change");

    // R4 R9 alternate build
    doWrite(1, 4'd1, swp(32'h0000_0ABC));
    check("R4 R9 set loads", outV[1], 32'h0000_0ABC);
    doWrite(1, 4'd1, swp(32'hF000_0003));
    check("R4 R7 zeros drive low", outV[1], 32'h0000_0003);
    doWrite(1, 4'd2, swp(32'h0000_0FFF));
    check("R4 clear word ignored", outV[1], 32'h0000_0003);
    doRead(1, 4'd1, swp(32'h0000_0003), "R11 R9 latch read alt");

    // R6 R9 inverted direction
    doWrite(1, 4'd3, swp(32'h0000_0F0F));
    check("R6 oe inverted", oeV[1], 32'h0000_00F0);

    // R8 input-only build
    doWrite(2, 4'd3, 32'hFFFF_FFFF);
    doWrite(2, 4'd1, 32'hFFFF_FFFF);
    check("R8 no drive", oeV[2], 32'h0);
    check("R8 out idle", outV[2], 32'h0);

    // R9 little-endian build has no reordering
    doWrite(0, 4'd2, 32'hFFFF_FFFF);
    doWrite(0, 4'd1, 32'h0000_0012);
    check("R9 no swap", outV[0], 32'h0000_0012);

    repeat (3) @(negedge clk);
    check("read queue drained", 32'(rdQ.size()), 32'd0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule